// File: doc/BRIEF.md
# Compare Output Enable Gating

This block sits between the compare logic of a PWM timer unit and the output pins. It takes two timer compare outputs and three full-compare outputs and decides, every cycle, which of them may drive their pins. A disabled output drives high impedance, which is modelled here as a per-output enable (`pwm_oe`) with the data held at 0. Active-low trip inputs pass through a two-flop synchroniser and then feed a sticky protect flag and an interrupt request.

A mode bit picks one of two enable schemes. Grouped mode is the reset default and stays compatible with older designs. In this mode one bit enables both timer outputs and one bit enables all three full-compare outputs. The interrupt mask gates both the trip path and the interrupt, and a set protect flag shuts every output at once. Independent mode gives each output its own enable and each trip its own enable. An enabled trip that is low shuts only its own output and sets the flag, and the mask then acts only on the interrupt. Software reaches the block through a small synchronous write port with a combinational read port.

Top module: `cmp_oe_gate`

## Requirements
- R1: After reset all register fields read 0, the mode is grouped, every `pwm_oe` bit is 0, and `prot_flag` and `irq` are 0.
- R2: In grouped mode (address 0 bit 0 = 0), `pwm_oe[1:0]` both follow address 1 bit 0, and `pwm_oe[4:2]` all follow address 1 bit 1.
- R3: In grouped mode with the mask (address 3 bit 1) at 1, any low synchronised trip sets `prot_flag` one clock later. While the flag is set, every `pwm_oe` bit is 0.
- R4: In grouped mode with the mask at 0, trip inputs neither set the flag nor change any output.
- R5: In independent mode (address 0 bit 0 = 1), `pwm_oe[i]` follows address 2 bit i. Bits 0 and 1 are the timer outputs and bits 2 to 4 are the full-compare outputs.
- R6: In independent mode, trip i is enabled by address 2 bit 8+i. An enabled trip that is low, after synchronisation, forces `pwm_oe[i]` to 0 and sets the flag. It does not affect any other output. A trip whose enable bit is 0 is ignored.
- R7: In independent mode, a set flag and the mask do not gate any output.
- R8: `irq` is 1 exactly when `prot_flag` is 1 and the mask bit is 1, in both modes.
- R9: Writing 1 to address 3 bit 0 clears the flag. Writing 0 there leaves it unchanged. A set condition in the same cycle wins over the clear.
- R10: Bits that the selected mode does not use are stored and read back, but have no effect: address 2 in grouped mode, and address 1 in independent mode.
- R11: `pwm_out[i]` equals compare input i (timers at 1:0, full-compare at 4:2) when `pwm_oe[i]` is 1, and 0 otherwise.
- R12: A trip input reaches the gating logic after two clock edges. An output in independent mode drops after the second edge. The flag sets after the third edge.
- R13: `reg_rdata` shows the register selected by `reg_addr` in the same cycle. Address 0 is the mode, address 1 is the two group bits, address 2 is the output enables at 4:0 and the trip enables at 12:8, and address 3 is the flag at bit 0 and the mask at bit 1. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_tmr_i | input | 2 | Timer compare outputs from upstream |
| cmp_full_i | input | 3 | Full-compare outputs from upstream |
| trip_n_i | input | 5 | Active-low trip inputs, one per output |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| pwm_out | output | 5 | Gated compare data |
| pwm_oe | output | 5 | Per-output drive enable (0 = high impedance) |
| prot_flag | output | 1 | Sticky protect flag |
| irq | output | 1 | Protect interrupt request |

## Verification
The bench checks that bits unused in each mode have no effect. A design that decoded both register sets at once would leave outputs on in grouped mode after only independent enables were written. It also tests a clear written in the same cycle as a live trip. A design that gave the clear priority would drop the flag while the fault is still present. In independent mode it lowers one enabled trip and one disabled trip side by side. A design that gated outputs from the flag instead of from the per-output trip would shut every output or none. The trip latency is compared edge by edge, so an extra or missing synchroniser stage shows up as a one-cycle shift in `pwm_oe` and `prot_flag`.

// File: rtl/cmp_oe_pkg.sv
package cmp_oe_pkg;

  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 2;
  localparam int TRIP_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE  = 2'd0,
    A_GROUP = 2'd1,
    A_INDEP = 2'd2,
    A_PROT  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic mode_ind;
    logic grp_tmr_en;
    logic grp_full_en;
    logic irq_mask;
  } ctrl_t;

  // grouped enables: first n_tmr bits take tmr_en, the rest up to n_out take full_en
  function automatic logic [DATA_W-1:0] group_oe(input int n_tmr, input int n_out,
                                                 input logic tmr_en, input logic full_en);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n_tmr)      v[i] = tmr_en;
      else if (i < n_out) v[i] = full_en;
    end
    return v;
  endfunction

  // per-output enables with per-output trip kill
  function automatic logic [DATA_W-1:0] indep_oe(input logic [DATA_W-1:0] en,
                                                 input logic [DATA_W-1:0] trip_en,
                                                 input logic [DATA_W-1:0] trip_low);
    return en & ~(trip_en & trip_low);
  endfunction

endpackage

// File: rtl/cmp_oe_sync.sv
module cmp_oe_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_n,
  output logic [W-1:0] q_n
);

  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '1;
        else        pipe[g] <= d_n;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '1;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q_n = pipe[STAGES-1];

endmodule

// File: rtl/cmp_oe_regs.sv
module cmp_oe_regs
  import cmp_oe_pkg::*;
#(
  parameter int NUM_OUT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              trip_hit,
  output ctrl_t             ctrl,
  output logic [NUM_OUT-1:0] out_en,
  output logic [NUM_OUT-1:0] trip_en,
  output logic              flag
);

  logic flag_clr;
  logic unused_wdata;

  assign flag_clr     = we && (addr == A_PROT) && wdata[0];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      out_en  <= '0;
      trip_en <= '0;
    end else if (we) begin
      case (reg_addr_e'(addr))
        A_MODE:  ctrl.mode_ind <= wdata[0];
        A_GROUP: begin
          ctrl.grp_tmr_en  <= wdata[0];
          ctrl.grp_full_en <= wdata[1];
        end
        A_INDEP: begin
          out_en  <= wdata[NUM_OUT-1:0];
          trip_en <= wdata[TRIP_LSB+NUM_OUT-1:TRIP_LSB];
        end
        A_PROT:  ctrl.irq_mask <= wdata[1];
        default: ;
      endcase
    end
  end

  // sticky flag: a set in the same cycle wins over the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag && !flag_clr) || trip_hit;
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      A_MODE:  rdata[0] = ctrl.mode_ind;
      A_GROUP: rdata[1:0] = {ctrl.grp_full_en, ctrl.grp_tmr_en};
      A_INDEP: begin
        rdata[NUM_OUT-1:0]                 = out_en;
        rdata[TRIP_LSB+NUM_OUT-1:TRIP_LSB] = trip_en;
      end
      A_PROT:  rdata[1:0] = {ctrl.irq_mask, flag};
      default: rdata = '0;
    endcase
  end

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    trip_hit |=> flag); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !trip_hit) |=> !flag); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R9

endmodule

// File: rtl/cmp_oe_mask.sv
module cmp_oe_mask
  import cmp_oe_pkg::*;
#(
  parameter int NUM_TMR  = 2,
  parameter int NUM_FULL = 3,
  localparam int NUM_OUT = NUM_TMR + NUM_FULL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_t              ctrl,
  input  logic [NUM_OUT-1:0] out_en,
  input  logic [NUM_OUT-1:0] trip_en,
  input  logic [NUM_OUT-1:0] trip_low,
  input  logic               flag,
  output logic [NUM_OUT-1:0] oe,
  output logic               trip_hit
);

  logic [DATA_W-1:0] grp_v;
  logic [DATA_W-1:0] ind_v;
  logic              unused_hi;

  assign grp_v = group_oe(NUM_TMR, NUM_OUT, ctrl.grp_tmr_en, ctrl.grp_full_en);
  assign ind_v = indep_oe(DATA_W'(out_en), DATA_W'(trip_en), DATA_W'(trip_low));
  assign unused_hi = ^{grp_v, ind_v};

  // grouped: mask gates the direct trip path; independent: per-trip enables
  assign trip_hit = ctrl.mode_ind ? |(trip_low & trip_en)
                                  : (ctrl.irq_mask && (|trip_low));

  always_comb begin
    if (ctrl.mode_ind) oe = ind_v[NUM_OUT-1:0];
    else if (flag)     oe = '0;
    else               oe = grp_v[NUM_OUT-1:0];
  end

  AST_GRP_FLAG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.mode_ind && flag) |-> (oe == '0)); // R3
  AST_IND_FLAG_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode_ind && trip_low == '0) |-> (oe == out_en)); // R7

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
    AST_IND_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.mode_ind && trip_en[g] && trip_low[g]) |-> !oe[g]); // R6
  end

endmodule

// File: rtl/cmp_oe_gate.sv
module cmp_oe_gate
  import cmp_oe_pkg::*;
#(
  parameter int NUM_TMR     = 2,
  parameter int NUM_FULL    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_TMR-1:0]          cmp_tmr_i,
  input  logic [NUM_FULL-1:0]         cmp_full_i,
  input  logic [NUM_TMR+NUM_FULL-1:0] trip_n_i,
  input  logic                        reg_we,
  input  logic [1:0]                  reg_addr,
  input  logic [15:0]                 reg_wdata,
  output logic [15:0]                 reg_rdata,
  output logic [NUM_TMR+NUM_FULL-1:0] pwm_out,
  output logic [NUM_TMR+NUM_FULL-1:0] pwm_oe,
  output logic                        prot_flag,
  output logic                        irq
);

  localparam int NUM_OUT = NUM_TMR + NUM_FULL;

  ctrl_t              ctrl;
  logic [NUM_OUT-1:0] out_en;
  logic [NUM_OUT-1:0] trip_en;
  logic [NUM_OUT-1:0] trip_sync_n;
  logic [NUM_OUT-1:0] trip_low;
  logic [NUM_OUT-1:0] cmp_all;
  logic               trip_hit;

  cmp_oe_sync #(.W(NUM_OUT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_n   (trip_n_i),
    .q_n   (trip_sync_n)
  );

  assign trip_low = ~trip_sync_n;

  cmp_oe_regs #(.NUM_OUT(NUM_OUT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .trip_hit (trip_hit),
    .ctrl     (ctrl),
    .out_en   (out_en),
    .trip_en  (trip_en),
    .flag     (prot_flag)
  );

  cmp_oe_mask #(.NUM_TMR(NUM_TMR), .NUM_FULL(NUM_FULL)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .out_en   (out_en),
    .trip_en  (trip_en),
    .trip_low (trip_low),
    .flag     (prot_flag),
    .oe       (pwm_oe),
    .trip_hit (trip_hit)
  );

  assign cmp_all = {cmp_full_i, cmp_tmr_i};
  assign pwm_out = cmp_all & pwm_oe;
  assign irq     = prot_flag && ctrl.irq_mask;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> prot_flag); // R8
  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_out & ~pwm_oe) == '0)); // R11

endmodule

// File: tb/cmp_oe_gate_tb.sv
module cmp_oe_gate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmp_tmr_i = '0;
  logic [2:0]  cmp_full_i = '0;
  logic [4:0]  trip_n_i = '1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [4:0]  pwm_out, pwm_oe;
  logic        prot_flag, irq;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference state
  bit         m_mode = 0;
  bit [1:0]   m_grp = '0;
  bit [4:0]   m_oen = '0, m_ten = '0;
  bit         m_mask = 0, m_flag = 0;
  logic [4:0] m_pipe[$];

  always #10 clk = ~clk;

  cmp_oe_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_tmr_i(cmp_tmr_i), .cmp_full_i(cmp_full_i),
    .trip_n_i(trip_n_i), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
    .prot_flag(prot_flag), .irq(irq)
  );

  initial begin
    m_pipe.push_back(5'h1f);
    m_pipe.push_back(5'h1f);
  end

  // model update on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_grp = '0; m_oen = '0; m_ten = '0; m_mask = 0; m_flag = 0;
      m_pipe.delete();
      m_pipe.push_back(5'h1f);
      m_pipe.push_back(5'h1f);
    end else begin
      bit [4:0] low;
      bit hit, clr;
      low = ~m_pipe[0];
      hit = m_mode ? (|(low & m_ten)) : (m_mask && (low != 0));
      clr = reg_we && reg_addr == 2'd3 && reg_wdata[0];
      m_flag = (m_flag && !clr) || hit;
      if (reg_we) begin
        case (reg_addr)
          2'd0: m_mode = reg_wdata[0];
          2'd1: m_grp  = reg_wdata[1:0];
          2'd2: begin m_oen = reg_wdata[4:0]; m_ten = reg_wdata[12:8]; end
          default: m_mask = reg_wdata[1];
        endcase
      end
      void'(m_pipe.pop_front());
      m_pipe.push_back(trip_n_i);
    end
  end

  // compare away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [4:0] e_oe, e_out;
      bit [15:0] e_rd;
      bit e_irq;
      if (m_mode) e_oe = m_oen & ~(m_ten & ~m_pipe[0]);
      else if (m_flag) e_oe = '0;
      else for (int i = 0; i < 5; i++) e_oe[i] = (i < 2) ? m_grp[0] : m_grp[1];
      e_out = {cmp_full_i, cmp_tmr_i} & e_oe;
      e_irq = m_flag && m_mask;
      case (reg_addr)
        2'd0: e_rd = {15'd0, m_mode};
        2'd1: e_rd = {14'd0, m_grp};
        2'd2: e_rd = {3'd0, m_ten, 3'd0, m_oen};
        default: e_rd = {14'd0, m_mask, m_flag};
      endcase
      checks++;
      if (pwm_oe !== e_oe || pwm_out !== e_out || prot_flag !== m_flag ||
          irq !== e_irq || reg_rdata !== e_rd) begin
        errors++;
        $display("FAIL %s oe=%b out=%b flag=%b irq=%b rd=%h expected oe=%b out=%b flag=%b irq=%b rd=%h",
                 cur_req, pwm_oe, pwm_out, prot_flag, irq, reg_rdata,
                 e_oe, e_out, m_flag, e_irq, e_rd);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #4;
      {cmp_full_i, cmp_tmr_i} = 5'($urandom);
      reg_we = 1'b0;
    end
  endtask

  task automatic wr(input bit [1:0] a, input bit [15:0] d);
    @(posedge clk); #4;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #4;
    reg_we = 1'b0;
  endtask

  task automatic sweep_reads();
    for (int a = 0; a < 4; a++) begin
      @(posedge clk); #4;
      reg_addr = 2'(a);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #4 rst_n = 1'b1;
    cur_req = "R1"; sweep_reads(); step(2);
    // R2 grouped enables
    cur_req = "R2"; wr(2'd1, 16'h0001); step(4);
    wr(2'd1, 16'h0002); step(4);
    wr(2'd1, 16'h0003); step(4);
    // R10 independent fields ignored in grouped mode
    cur_req = "R10"; wr(2'd1, 16'h0000); wr(2'd2, 16'h1f1f); step(3);
    trip_n_i = 5'b11110; step(4); trip_n_i = '1; step(3);
    // R4 mask off: trip ignored
    cur_req = "R4"; wr(2'd1, 16'h0003); trip_n_i = 5'b11011; step(5);
    trip_n_i = '1; step(3);
    // R3 and R12 grouped trip with mask on
    cur_req = "R3"; wr(2'd3, 16'h0002);
    @(posedge clk); #4 trip_n_i = 5'b11110;
    cur_req = "R12"; step(4);
    cur_req = "R8"; reg_addr = 2'd3; step(2);
    // R9 clear while the trip is still low: set wins
    cur_req = "R9"; wr(2'd3, 16'h0003); step(2);
    trip_n_i = '1; step(3);
    wr(2'd3, 16'h0002); step(2);  // writing 0 to the flag: no change
    wr(2'd3, 16'h0003); step(3);  // clear
    // R5 independent enables
    cur_req = "R5"; wr(2'd0, 16'h0001); wr(2'd2, 16'h0015); step(4);
    wr(2'd2, 16'h000b); step(4);
    // R10 group bits ignored in independent mode
    cur_req = "R10"; wr(2'd1, 16'h0000); step(3); wr(2'd1, 16'h0003); step(2);
    // R6 per-trip: trip 1 enabled, trip 2 not
    cur_req = "R6"; wr(2'd2, 16'h021f); reg_addr = 2'd2;
    @(posedge clk); #4 trip_n_i = 5'b11001;
    cur_req = "R12"; step(4);
    // R7 flag set does not gate outputs once trips release
    cur_req = "R7"; trip_n_i = '1; step(4);
    wr(2'd3, 16'h0000); step(3);
    cur_req = "R8"; wr(2'd3, 16'h0002); reg_addr = 2'd3; step(2);
    cur_req = "R9"; wr(2'd3, 16'h0003); step(3);
    // R11 data gating under a changing enable pattern
    cur_req = "R11"; wr(2'd2, 16'h001a); step(6);
    cur_req = "R13"; sweep_reads(); step(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule